// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block listens to the two wires of an I2C bus as a target device and decides whether the master is addressing it. It resynchronises the sampled clock and data lines into the system clock domain and finds START and STOP conditions. After each START it shifts in the address byte, most significant bit first. It then compares the seven address bits with a programmed own address. It can also accept the all-zero general-call address, which every device on the bus receives.

When the address is accepted, the block pulls SDA low for the acknowledge clock and raises a one-cycle match strobe. It also reports the transfer direction, flags a general call and presents a status code. Software or a downstream data engine then takes over the transfer. The data phase after the acknowledge is outside this block, which waits for the next START or STOP. When the acknowledge-enable input is low, the block leaves the bus untouched and answers nothing.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset the SDA pull-down, match strobe, direction and general-call outputs are 0 and the status output is 0xF8.
- R2: A START (SDA falling while SCL is high) begins address capture. When the seven address bits equal the own address held in config bits 7..1 and the eighth bit (R/W, sampled on the eighth SCL rise) is 0, the block acknowledges, reports status 0x60 and sets the direction output to 0.
- R3: An own-address match with R/W = 1 (read) reports status 0xA8 and sets the direction output to 1.
- R4: When config bit 0 (general-call enable) is 1, address 0x00 with R/W = 0 is acknowledged with status 0x70, the general-call output set to 1 and the direction output set to 0.
- R5: When config bit 0 is 0, address 0x00 is not acknowledged, raises no strobe, and the status reads 0xF8 after the transfer.
- R6: Address 0x00 with R/W = 1 is never acknowledged, even with general-call enable set.
- R7: While the acknowledge-enable input is 0, no address is acknowledged. If it falls during the acknowledge window, the pull-down is released on the next cycle.
- R8: An address that equals neither the own address nor an enabled general call is not acknowledged and leaves status 0xF8. An own address of 0 is only ever matched as a general call.
- R9: The SDA pull-down starts after the falling edge of the eighth SCL pulse. It is held through the high phase of the ninth pulse and is released after the ninth falling edge, so it only changes while SCL is low.
- R10: A repeated START in the middle of an address restarts capture from the first bit.
- R11: A STOP (SDA rising while SCL is high) abandons any capture. Clock pulses that follow without a new START are ignored.
- R12: The match strobe lasts exactly one cycle and fires once for each acknowledged address. Status, direction and general-call outputs hold their values until the next START clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| addr_cfg_i | input | ADDR_W+1 | Own address in bits ADDR_W..1, general-call enable in bit 0 |
| ack_en_i | input | 1 | Acknowledge enable; 0 disconnects the block from the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| match_stb_o | output | 1 | One-cycle pulse on an accepted address |
| dir_rd_o | output | 1 | 1 when the accepted transfer is a read |
| gen_call_o | output | 1 | 1 when the accepted address is a general call |
| status_o | output | 8 | 0xF8 none, 0x60 own write, 0xA8 own read, 0x70 general call |

## Verification
The assertions assume the bus is slow compared with the system clock. Each SCL and SDA level must stay put for several cycles, longer than the synchroniser plus the edge-detect stage. Otherwise a pull-down change could land after SCL has already risen. The bench holds every bus phase for eight clocks and changes SDA only while SCL is low, except when it deliberately forms START and STOP conditions. It models the shared SDA wire as the AND of the master's drive and the inverse of the pull-down.

// File: rtl/i2c_arec_pkg.sv
package i2c_arec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_HOLD
    } arec_state_e;

    localparam logic [7:0] CODE_NONE   = 8'hF8;
    localparam logic [7:0] CODE_OWN_WR = 8'h60;
    localparam logic [7:0] CODE_OWN_RD = 8'hA8;
    localparam logic [7:0] CODE_GCALL  = 8'h70;

endpackage

// File: rtl/i2c_arec_bus_cond.sv
module i2c_arec_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl;
        logic [SYNC_STAGES-1:0] sda;
        logic                   scl_prev;
        logic                   sda_prev;
    } cond_t;

    cond_t cond_d, cond_q;

    // synchroniser chain and one-cycle history of the sampled lines
    always_comb begin
        cond_d        = cond_q;
        cond_d.scl[0] = scl_i;
        cond_d.sda[0] = sda_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            cond_d.scl[k] = cond_q.scl[k-1];
            cond_d.sda[k] = cond_q.sda[k-1];
        end
        cond_d.scl_prev = cond_q.scl[LAST];
        cond_d.sda_prev = cond_q.sda[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= {$bits(cond_t){1'b1}};
        end else begin
            cond_q <= cond_d;
        end
    end

    assign scl_s_o = cond_q.scl[LAST];
    assign sda_s_o = cond_q.sda[LAST];
    assign start_o = cond_q.scl_prev & scl_s_o & cond_q.sda_prev & ~sda_s_o;
    assign stop_o  = cond_q.scl_prev & scl_s_o & ~cond_q.sda_prev & sda_s_o;
    assign rise_o  = ~cond_q.scl_prev & scl_s_o;
    assign fall_o  = cond_q.scl_prev & ~scl_s_o;

endmodule

// File: rtl/i2c_arec_match.sv
module i2c_arec_match
    import i2c_arec_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   rx_byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              ack_en_i,
    output logic              hit_o,
    output logic              hit_gc_o,
    output logic              dir_rd_o,
    output logic [7:0]        code_o
);

    logic [ADDR_W-1:0] addr_field;
    logic              rw_bit;
    logic              is_zero;
    logic              own_hit;
    logic              gc_hit;

    always_comb begin
        addr_field = rx_byte_i[ADDR_W:1];
        rw_bit     = rx_byte_i[0];
        is_zero    = (addr_field == '0);
        own_hit    = !is_zero && (addr_field == own_addr_i);
        gc_hit     = is_zero && gc_en_i && !rw_bit;
        hit_o      = ack_en_i && (own_hit || gc_hit);
        hit_gc_o   = gc_hit;
        dir_rd_o   = rw_bit;
        if (gc_hit) begin
            code_o = CODE_GCALL;
        end else if (rw_bit) begin
            code_o = CODE_OWN_RD;
        end else begin
            code_o = CODE_OWN_WR;
        end
    end

endmodule

// File: rtl/i2c_arec_fsm.sv
module i2c_arec_fsm
    import i2c_arec_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_s_i,
    input  logic              ack_en_i,
    input  logic              hit_i,
    input  logic              hit_gc_i,
    input  logic              hit_rd_i,
    input  logic [7:0]        hit_code_i,
    output logic [ADDR_W:0]   rx_byte_o,
    output logic              sda_pull_o,
    output logic              match_stb_o,
    output logic              dir_rd_o,
    output logic              gen_call_o,
    output logic [7:0]        status_o
);

    localparam int                CNT_W     = $clog2(ADDR_W + 2);
    localparam logic [CNT_W-1:0]  BITS_LAST = CNT_W'(ADDR_W + 1);

    typedef struct packed {
        arec_state_e        state;
        logic [ADDR_W:0]    shreg;
        logic [CNT_W-1:0]   cnt;
        logic               pull;
        logic               stb;
        logic               dir;
        logic               gc;
        logic [7:0]         code;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.stb = 1'b0;
        if (start_i) begin
            fsm_d.state = ST_ADDR;
            fsm_d.shreg = '0;
            fsm_d.cnt   = '0;
            fsm_d.pull  = 1'b0;
            fsm_d.dir   = 1'b0;
            fsm_d.gc    = 1'b0;
            fsm_d.code  = CODE_NONE;
        end else if (stop_i) begin
            fsm_d.state = ST_IDLE;
            fsm_d.pull  = 1'b0;
        end else begin
            unique case (fsm_q.state)
                ST_ADDR: begin
                    if (rise_i && fsm_q.cnt != BITS_LAST) begin
                        fsm_d.shreg = {fsm_q.shreg[ADDR_W-1:0], sda_s_i};
                        fsm_d.cnt   = fsm_q.cnt + 1'b1;
                    end else if (fall_i && fsm_q.cnt == BITS_LAST) begin
                        if (hit_i) begin
                            fsm_d.state = ST_ACK;
                            fsm_d.pull  = 1'b1;
                            fsm_d.stb   = 1'b1;
                            fsm_d.dir   = hit_rd_i;
                            fsm_d.gc    = hit_gc_i;
                            fsm_d.code  = hit_code_i;
                        end else begin
                            fsm_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (!ack_en_i) begin
                        fsm_d.pull  = 1'b0;
                        fsm_d.state = ST_IDLE;
                    end else if (fall_i) begin
                        fsm_d.pull  = 1'b0;
                        fsm_d.state = ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, shreg: '0, cnt: '0, pull: 1'b0,
                       stb: 1'b0, dir: 1'b0, gc: 1'b0, code: CODE_NONE};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rx_byte_o   = fsm_q.shreg;
    assign sda_pull_o  = fsm_q.pull;
    assign match_stb_o = fsm_q.stb;
    assign dir_rd_o    = fsm_q.dir;
    assign gen_call_o  = fsm_q.gc;
    assign status_o    = fsm_q.code;

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [ADDR_W:0] addr_cfg_i,
    input  logic            ack_en_i,
    output logic            sda_pull_o,
    output logic            match_stb_o,
    output logic            dir_rd_o,
    output logic            gen_call_o,
    output logic [7:0]      status_o
);

    logic            scl_s;
    logic            sda_s;
    logic            cond_start;
    logic            cond_stop;
    logic            cond_rise;
    logic            cond_fall;
    logic [ADDR_W:0] rx_byte;
    logic            hit;
    logic            hit_gc;
    logic            hit_rd;
    logic [7:0]      hit_code;

    i2c_arec_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_s_o (scl_s),
        .sda_s_o (sda_s),
        .start_o (cond_start),
        .stop_o  (cond_stop),
        .rise_o  (cond_rise),
        .fall_o  (cond_fall)
    );

    i2c_arec_match #(.ADDR_W(ADDR_W)) match_i (
        .rx_byte_i  (rx_byte),
        .own_addr_i (addr_cfg_i[ADDR_W:1]),
        .gc_en_i    (addr_cfg_i[0]),
        .ack_en_i   (ack_en_i),
        .hit_o      (hit),
        .hit_gc_o   (hit_gc),
        .dir_rd_o   (hit_rd),
        .code_o     (hit_code)
    );

    i2c_arec_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (cond_start),
        .stop_i      (cond_stop),
        .rise_i      (cond_rise),
        .fall_i      (cond_fall),
        .sda_s_i     (sda_s),
        .ack_en_i    (ack_en_i),
        .hit_i       (hit),
        .hit_gc_i    (hit_gc),
        .hit_rd_i    (hit_rd),
        .hit_code_i  (hit_code),
        .rx_byte_o   (rx_byte),
        .sda_pull_o  (sda_pull_o),
        .match_stb_o (match_stb_o),
        .dir_rd_o    (dir_rd_o),
        .gen_call_o  (gen_call_o),
        .status_o    (status_o)
    );

endmodule

// File: rtl/i2c_addr_recognizer_chk.sv
module i2c_addr_recognizer_chk
    import i2c_arec_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       ack_en_i,
    input logic       sda_pull_o,
    input logic       match_stb_o,
    input logic       dir_rd_o,
    input logic       gen_call_o,
    input logic [7:0] status_o
);

    // R12
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_stb_o |=> !match_stb_o);

    // R2
    stb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_stb_o |-> (status_o == CODE_OWN_WR || status_o == CODE_OWN_RD
                         || status_o == CODE_GCALL));

    // R3
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_stb_o && status_o == CODE_OWN_RD) |-> dir_rd_o);

    // R4
    gc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_call_o |-> (!dir_rd_o && status_o == CODE_GCALL));

    // R7
    ack_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o && !ack_en_i) |=> !sda_pull_o);

    // R9
    pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);

    // R9
    pull_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull_o) && $past(ack_en_i)) |-> !scl_s);

endmodule

bind i2c_addr_recognizer i2c_addr_recognizer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .ack_en_i    (ack_en_i),
    .sda_pull_o  (sda_pull_o),
    .match_stb_o (match_stb_o),
    .dir_rd_o    (dir_rd_o),
    .gen_call_o  (gen_call_o),
    .status_o    (status_o)
);

// File: tb/i2c_addr_recognizer_tb_top.sv
module i2c_addr_recognizer_tb_top;

    localparam int Q = 8;

    typedef struct {
        logic [7:0] code;
        logic       dir;
        logic       gc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [7:0] cfg = 8'h00;
    logic       ack_en = 1'b1;
    logic       sda_pull;
    logic       match_stb;
    logic       dir_rd;
    logic       gen_call;
    logic [7:0] status;
    logic       sda_bus;

    int   checks = 0;
    int   fails = 0;
    int   stb_seen = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    i2c_addr_recognizer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .addr_cfg_i  (cfg),
        .ack_en_i    (ack_en),
        .sda_pull_o  (sda_pull),
        .match_stb_o (match_stb),
        .dir_rd_o    (dir_rd),
        .gen_call_o  (gen_call),
        .status_o    (status)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe (R12)
    always @(negedge clk) begin
        if (rst_n && match_stb) begin
            stb_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(status == e.code, "R2/R3/R4 status", status, e.code);
                chk(dir_rd == e.dir, "R3 direction", dir_rd, e.dir);
                chk(gen_call == e.gc, "R4 general call", gen_call, e.gc);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    // full address phase plus ack clock, with scoreboard push
    task automatic xact(input logic [6:0] a, input logic rw, input string rq);
        bit         own_ok;
        bit         gc_ok;
        bit         exp_ack;
        int         stb0;
        logic [7:0] ecode;
        exp_t       e;
        own_ok  = (a != 7'd0) && (a == cfg[7:1]);
        gc_ok   = (a == 7'd0) && cfg[0] && !rw;
        exp_ack = ack_en && (own_ok || gc_ok);
        ecode   = gc_ok ? 8'h70 : (rw ? 8'hA8 : 8'h60);
        if (exp_ack) begin
            e.code = ecode; e.dir = rw; e.gc = gc_ok;
            exp_q.push_back(e);
        end
        stb0 = stb_seen;
        bus_start();
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
        // R9: pull present in low phase after 8th fall
        m_sda = 1'b1; wq();
        chk(sda_pull == exp_ack, {rq, " R9 ack before 9th rise"}, sda_pull, exp_ack);
        m_scl = 1'b1; wq();
        chk(sda_bus == !exp_ack, {rq, " ack level on 9th high"}, sda_bus, !exp_ack);
        m_scl = 1'b0; wq();
        chk(sda_pull == 1'b0, {rq, " R9 release after 9th fall"}, sda_pull, 0);
        bus_stop();
        chk(status == (exp_ack ? ecode : 8'hF8), {rq, " R12 status held"}, status,
            exp_ack ? ecode : 8'hF8);
        chk((stb_seen - stb0) == (exp_ack ? 1 : 0), {rq, " R12 strobe count"},
            stb_seen - stb0, exp_ack ? 1 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(sda_pull == 1'b0, "R1 pull at reset", sda_pull, 0);
        chk(match_stb == 1'b0, "R1 strobe at reset", match_stb, 0);
        chk(dir_rd == 1'b0 && gen_call == 1'b0, "R1 dir/gc at reset", {dir_rd, gen_call}, 0);
        chk(status == 8'hF8, "R1 status at reset", status, 8'hF8);

        cfg = {7'h2A, 1'b0};
        xact(7'h2A, 1'b0, "R2 own write");
        xact(7'h2A, 1'b1, "R3 own read");
        xact(7'h2B, 1'b0, "R8 mismatch");
        xact(7'h00, 1'b0, "R5 gc disabled");
        cfg = {7'h2A, 1'b1};
        xact(7'h00, 1'b0, "R4 gc enabled");
        xact(7'h00, 1'b1, "R6 gc read");
        xact(7'h55, 1'b1, "R8 other read");
        cfg = {7'h00, 1'b0};
        xact(7'h00, 1'b0, "R8 own zero");
        cfg = {7'h13, 1'b1};
        ack_en = 1'b0;
        xact(7'h13, 1'b0, "R7 ack off own");
        xact(7'h00, 1'b0, "R7 ack off gc");
        ack_en = 1'b1;
        xact(7'h13, 1'b1, "R3 second address");

        // R10: repeated START mid-address restarts capture
        begin
            exp_t e;
            int   stb0;
            e.code = 8'h60; e.dir = 1'b0; e.gc = 1'b0;
            exp_q.push_back(e);
            stb0 = stb_seen;
            bus_start();
            send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
            bus_start();
            for (int i = 6; i >= 0; i--) send_bit(cfg[i+1]);
            send_bit(1'b0);
            m_sda = 1'b1; m_scl = 1'b0; wq();
            m_scl = 1'b1; wq();
            chk(sda_pull == 1'b1, "R10 ack after restart", sda_pull, 1);
            m_scl = 1'b0; wq();
            bus_stop();
            chk(stb_seen - stb0 == 1, "R10 one strobe", stb_seen - stb0, 1);
            chk(status == 8'h60, "R10 status", status, 8'h60);
        end

        // R11: STOP mid-address, then clocks without START are ignored
        begin
            int stb0;
            stb0 = stb_seen;
            bus_start();
            send_bit(1'b0); send_bit(1'b0);
            bus_stop();
            m_scl = 1'b0; wq();
            for (int i = 6; i >= 0; i--) send_bit(cfg[i+1]);
            send_bit(1'b0);
            m_sda = 1'b1; wq();
            m_scl = 1'b1; wq();
            chk(sda_pull == 1'b0, "R11 no ack without START", sda_pull, 0);
            m_scl = 1'b0; wq();
            bus_stop();
            chk(stb_seen - stb0 == 0, "R11 no strobe", stb_seen - stb0, 0);
        end

        // R7: ack-enable dropped inside the acknowledge window
        begin
            exp_t e;
            e.code = 8'h60; e.dir = 1'b0; e.gc = 1'b0;
            exp_q.push_back(e);
            bus_start();
            for (int i = 6; i >= 0; i--) send_bit(cfg[i+1]);
            send_bit(1'b0);
            m_sda = 1'b1; wq();
            chk(sda_pull == 1'b1, "R7 pull before drop", sda_pull, 1);
            ack_en = 1'b0;
            repeat (2) @(negedge clk);
            chk(sda_pull == 1'b0, "R7 release on drop", sda_pull, 0);
            m_scl = 1'b1; wq();
            m_scl = 1'b0; wq();
            bus_stop();
            ack_en = 1'b1;
        end

        chk(exp_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule